// File: doc/BRIEF.md
# Page-Map Address Translator

This block turns transfer virtual addresses into physical memory addresses through a programmable table of page-map entries. Each entry holds a valid flag and a page frame number. A page is 512 bytes. The upper virtual address bits pick an entry, and the frame number is joined to the in-page offset to form the physical address. Software fills the table through a plain host register port. The transfer engine sends lookups over a valid/ready request channel and takes results from a valid/ready response channel.

Every accepted lookup leaves a copy of the entry it selected in a read-only shadow output, whether or not the entry is valid. A lookup that lands on an invalid entry returns no address. It also raises a one-cycle invalid-map event, which the status logic uses to abort the transfer.

Back-pressure rules:
- The request side is ready only while no response is pending, or while the pending response is being taken in that same cycle.
- A pending response stays unchanged until `rsp_ready` is high.
- An adapter init clears pending work and the shadow, but leaves the table alone.
- Only the power-up reset zeroes the table.

Top module: `pgmap_xlat`

## Requirements
- R1: After `rst_n` is low, every map entry reads as zero, `sel_entry` is zero and `rsp_valid` is low.
- R2: A host access with `hst_addr[11:10]` equal to 2 reaches map entry `hst_addr[9:2]`. A write stores bit 31 (valid) and bits 20:0 (page frame). A read returns that word, with all other bits zero, on `hst_rdata` one cycle after the request.
- R3: A host access with `hst_addr[11:10]` not equal to 2 changes no map entry, and a read of it returns zero.
- R4: An accepted lookup of a valid entry gives `rsp_ok`=1 and `rsp_pa` = {frame, `lk_va[8:0]`}, using entry `lk_va[16:9]`, with `rsp_valid` high in the cycle after acceptance.
- R5: An accepted lookup of an invalid entry gives `rsp_ok`=0 and `rsp_pa`=0, and `inv_evt` is high for exactly the one cycle after acceptance.
- R6: Every accepted lookup copies the selected entry, in its read-back form, into `sel_entry`, whether the entry is valid or not.
- R7: `lk_ready` equals (not `rsp_valid` or `rsp_ready`) and not `adp_init`. A response stays stable while `rsp_ready` is low.
- R8: If a host write and an accepted lookup hit the same entry in the same cycle, the lookup sees the old entry value.
- R9: `adp_init` clears `sel_entry` and any pending response, but leaves the map contents unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset; zeroes the map |
| adp_init | input | 1 | Adapter init; clears shadow and response, keeps map |
| hst_en | input | 1 | Host access strobe |
| hst_we | input | 1 | Host write (1) or read (0) |
| hst_addr | input | 12 | Host register address |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, one cycle after request |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted when high with lk_valid |
| lk_va | input | 17 | Lookup virtual address |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_pa | output | 30 | Physical address (zero when invalid) |
| rsp_ok | output | 1 | Entry was valid |
| sel_entry | output | 32 | Shadow copy of the last selected entry |
| inv_evt | output | 1 | One-cycle invalid-map event |

## Verification
The hardest case to reach from the ports is a host write and a lookup colliding on the same entry in one edge. A second hard case is a response held under back-pressure while another request waits. The bench drives the write and the lookup in the same cycle and compares the result against the entry's previous contents. It then stalls `rsp_ready` for several cycles with a second request presented, and checks that the held response does not change and that the second request is taken on the release edge. The rest of the table is swept: all 256 entries are filled with arithmetically derived frames, with every third entry invalid, and each entry is read back and translated.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;
  localparam int VA_W    = 17;
  localparam int OFS_W   = 9;
  localparam int IDX_W   = VA_W - OFS_W;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int PFN_W   = 21;
  localparam int PA_W    = PFN_W + OFS_W;
  localparam int WORD_W  = 32;
  localparam int VLD_BIT = 31;
  localparam int HA_W    = 12;
  localparam logic [1:0] MAP_REGION = 2'd2;

  typedef struct packed {
    logic             vld;
    logic [PFN_W-1:0] pfn;
  } map_ent_t;

  function automatic logic [WORD_W-1:0] ent_word(map_ent_t e);
    logic [WORD_W-1:0] w;
    w = '0;
    w[VLD_BIT] = e.vld;
    w[PFN_W-1:0] = e.pfn;
    return w;
  endfunction

  function automatic map_ent_t word_ent(logic [WORD_W-1:0] w);
    map_ent_t e;
    e.vld = w[VLD_BIT];
    e.pfn = w[PFN_W-1:0];
    return e;
  endfunction
endpackage

// File: rtl/pgmap_decode.sv
module pgmap_decode
  import pgmap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hst_en,
  input  logic             hst_we,
  input  logic [HA_W-1:0]  hst_addr,
  output logic             map_we,
  output logic             map_re,
  output logic [IDX_W-1:0] map_idx
);
  logic hit;
  assign hit     = hst_addr[11:10] == MAP_REGION;
  assign map_idx = hst_addr[IDX_W+1:2];
  assign map_we  = hst_en && hst_we && hit;
  assign map_re  = hst_en && !hst_we && hit;

  // R3
  outside_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_en && hst_addr[11:10] != MAP_REGION) |-> !(map_we || map_re));
endmodule

// File: rtl/pgmap_store.sv
module pgmap_store
  import pgmap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  map_ent_t         wdat,
  input  logic [IDX_W-1:0] hidx,
  output map_ent_t         hdat,
  input  logic [IDX_W-1:0] lidx,
  output map_ent_t         ldat
);
  map_ent_t mem [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdat;
    end
  end

  assign hdat = mem[hidx];
  assign ldat = mem[lidx];

  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(widx)] == $past(wdat));
endmodule

// File: rtl/pgmap_lookup.sv
module pgmap_lookup
  import pgmap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adp_init,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [VA_W-1:0]   lk_va,
  output logic [IDX_W-1:0]  lidx,
  input  map_ent_t          ldat,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_pa,
  output logic              rsp_ok,
  output logic [WORD_W-1:0] sel_entry,
  output logic              inv_evt
);
  logic accept;
  assign lidx     = lk_va[VA_W-1:OFS_W];
  assign lk_ready = !adp_init && (!rsp_valid || rsp_ready);
  assign accept   = lk_valid && lk_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_pa    <= '0;
      sel_entry <= '0;
      inv_evt   <= 1'b0;
    end else if (adp_init) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_pa    <= '0;
      sel_entry <= '0;
      inv_evt   <= 1'b0;
    end else begin
      inv_evt <= accept && !ldat.vld;
      if (accept) begin
        rsp_valid <= 1'b1;
        rsp_ok    <= ldat.vld;
        rsp_pa    <= ldat.vld ? {ldat.pfn, lk_va[OFS_W-1:0]} : '0;
        sel_entry <= ent_word(ldat);
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  // R5
  inv_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_evt |-> (rsp_valid && !rsp_ok && rsp_pa == '0));
  // R6
  shadow_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> sel_entry[VLD_BIT] == rsp_ok);
  // R7
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready && !adp_init) |=>
      (rsp_valid && $stable(rsp_pa) && $stable(rsp_ok)));
  // R9
  init_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adp_init |=> (!rsp_valid && sel_entry == '0));
endmodule

// File: rtl/pgmap_xlat.sv
module pgmap_xlat
  import pgmap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adp_init,
  input  logic              hst_en,
  input  logic              hst_we,
  input  logic [HA_W-1:0]   hst_addr,
  input  logic [WORD_W-1:0] hst_wdata,
  output logic [WORD_W-1:0] hst_rdata,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [VA_W-1:0]   lk_va,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_pa,
  output logic              rsp_ok,
  output logic [WORD_W-1:0] sel_entry,
  output logic              inv_evt
);
  logic             map_we, map_re;
  logic [IDX_W-1:0] map_idx, lidx;
  map_ent_t         hdat, ldat;

  pgmap_decode u_dec (
    .clk(clk), .rst_n(rst_n), .hst_en(hst_en), .hst_we(hst_we),
    .hst_addr(hst_addr), .map_we(map_we), .map_re(map_re), .map_idx(map_idx)
  );

  pgmap_store u_store (
    .clk(clk), .rst_n(rst_n), .we(map_we), .widx(map_idx),
    .wdat(word_ent(hst_wdata)), .hidx(map_idx), .hdat(hdat),
    .lidx(lidx), .ldat(ldat)
  );

  pgmap_lookup u_lk (
    .clk(clk), .rst_n(rst_n), .adp_init(adp_init),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_va(lk_va),
    .lidx(lidx), .ldat(ldat),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa),
    .rsp_ok(rsp_ok), .sel_entry(sel_entry), .inv_evt(inv_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hst_rdata <= '0;
    else        hst_rdata <= map_re ? ent_word(hdat) : '0;
  end

  // R2
  rdata_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hst_rdata[VLD_BIT-1:PFN_W] == '0);
  // R7
  ready_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adp_init |-> !lk_ready);
endmodule

// File: tb/pgmap_xlat_tb.sv
module pgmap_xlat_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        adp_init = 0;
  logic        hst_en = 0, hst_we = 0;
  logic [11:0] hst_addr = 0;
  logic [31:0] hst_wdata = 0;
  logic [31:0] hst_rdata;
  logic        lk_valid = 0, lk_ready;
  logic [16:0] lk_va = 0;
  logic        rsp_valid, rsp_ready = 1, rsp_ok, inv_evt;
  logic [29:0] rsp_pa;
  logic [31:0] sel_entry;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  pgmap_xlat u_dut (
    .clk(clk), .rst_n(rst_n), .adp_init(adp_init), .hst_en(hst_en), .hst_we(hst_we),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_va(lk_va),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa), .rsp_ok(rsp_ok),
    .sel_entry(sel_entry), .inv_evt(inv_evt)
  );

  function automatic logic [20:0] pfn_of(int i);
    return 21'((i * 2731 + 19) & 21'h1FFFFF);
  endfunction
  function automatic logic vld_of(int i);
    return (i % 3) != 0;
  endfunction
  function automatic logic [31:0] word_of(int i);
    return {vld_of(i), 10'b0, pfn_of(i)};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic [11:0] a, logic [31:0] d);
    hst_en = 1; hst_we = 1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_en = 0; hst_we = 0;
  endtask

  task automatic hread(logic [11:0] a, output logic [31:0] d);
    hst_en = 1; hst_we = 0; hst_addr = a;
    @(negedge clk);
    hst_en = 0;
    d = hst_rdata;
  endtask

  task automatic lookup(logic [16:0] va);
    lk_valid = 1; lk_va = va;
    @(negedge clk);
    lk_valid = 0;
  endtask

  function automatic logic [11:0] maddr(int i);
    return {2'b10, 8'(i), 2'b00};
  endfunction

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sel_entry", sel_entry, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R7 ready idle", lk_ready, 1);
    for (int i = 0; i < 256; i += 51) begin
      hread(maddr(i), d); chk("R1 entry zero", d, 0);
    end

    // R2 fill every entry with junk in the unused bits
    for (int i = 0; i < 256; i++)
      hwrite(maddr(i), word_of(i) | 32'h5AE0_0000);
    for (int i = 0; i < 256; i++) begin
      hread(maddr(i), d); chk("R2 readback", d, word_of(i));
    end

    // R3 accesses outside the map region
    hwrite({2'b01, 8'd7, 2'b00}, 32'h8000_1234);
    hwrite({2'b11, 8'd7, 2'b00}, 32'h8000_1234);
    hread({2'b01, 8'd7, 2'b00}, d); chk("R3 outside read zero", d, 0);
    hread(maddr(7), d); chk("R3 entry untouched", d, word_of(7));

    // R4/R5/R6 sweep every entry
    for (int i = 0; i < 256; i++) begin
      logic [8:0] off;
      off = 9'((i * 53 + 7) & 511);
      lookup({8'(i), off});
      chk("R4 rsp_valid", rsp_valid, 1);
      chk("R6 shadow", sel_entry, word_of(i));
      if (vld_of(i)) begin
        chk("R4 ok", rsp_ok, 1);
        chk("R4 pa", rsp_pa, {pfn_of(i), off});
        chk("R5 no event", inv_evt, 0);
      end else begin
        chk("R5 ok low", rsp_ok, 0);
        chk("R5 pa zero", rsp_pa, 0);
        chk("R5 event", inv_evt, 1);
      end
    end
    @(negedge clk);
    chk("R5 event one cycle", inv_evt, 0);
    chk("R7 drained", rsp_valid, 0);

    // R7 back-pressure
    rsp_ready = 0;
    lookup({8'd4, 9'd3});
    lk_valid = 1; lk_va = {8'd5, 9'd9};
    #1;
    chk("R7 ready low", lk_ready, 0);
    @(negedge clk); @(negedge clk);
    chk("R7 held valid", rsp_valid, 1);
    chk("R7 held pa", rsp_pa, {pfn_of(4), 9'd3});
    rsp_ready = 1;
    #1;
    chk("R7 ready on release", lk_ready, 1);
    @(negedge clk);
    lk_valid = 0;
    chk("R7 next pa", rsp_pa, {pfn_of(5), 9'd9});
    @(negedge clk);

    // R8 same-cycle write and lookup
    hst_en = 1; hst_we = 1; hst_addr = maddr(10); hst_wdata = 32'h8000_0ABC;
    lk_valid = 1; lk_va = {8'd10, 9'd1};
    @(negedge clk);
    hst_en = 0; hst_we = 0; lk_valid = 0;
    chk("R8 old pa", rsp_pa, {pfn_of(10), 9'd1});
    chk("R8 old shadow", sel_entry, word_of(10));
    lookup({8'd10, 9'd1});
    chk("R8 new pa", rsp_pa, {21'h000ABC, 9'd1});

    // R9 init
    rsp_ready = 0;
    lookup({8'd11, 9'd0});
    adp_init = 1;
    @(negedge clk);
    adp_init = 0;
    rsp_ready = 1;
    chk("R9 rsp cleared", rsp_valid, 0);
    chk("R9 shadow cleared", sel_entry, 0);
    hread(maddr(11), d); chk("R9 map kept", d, word_of(11));

    // R1 power reset clears the map
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    hread(maddr(11), d); chk("R1 map cleared", d, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule